// File: doc/BRIEF.md
# UART Transmit Path with 16-Entry Holding FIFO

This block is the transmit half of one serial channel. Host writes land in a byte FIFO that serves as the holding register. When the serializer is idle, it pulls the oldest byte, frames it and drives it onto a TX line that rests high. The width of each serial bit comes from the system clock divided by a programmable divisor. That divisor yields a 16x tick, and every bit lasts 16 ticks.

The FIFO can run in one of two modes. In single-byte (legacy) mode it holds at most one character. The holding-empty interrupt is then raised whenever that one slot is vacant, and writing a character clears it. In FIFO mode the full 16-entry depth is used. The interrupt then follows a selectable fill threshold instead. Status outputs report the fill level, a full holding register, an empty holding register, and a fully idle transmitter.

Top module: `uart_tx_path`

## Requirements
- R1: In FIFO mode (`fifo_mode`=1) up to 16 bytes are held and sent in write order. A write while `fifo_full` is high is discarded and leaves `fifo_level` unchanged.
- R2: In legacy mode (`fifo_mode`=0) the holding register holds one byte. `fifo_full` rises as soon as one byte is held, and any further write is discarded until the byte moves to the serializer.
- R3: A byte leaves the holding FIFO only when the serializer is idle. Two queued characters start one clock apart plus a full frame: the start-to-start spacing is frame_bits*16*divisor + 1 cycles.
- R4: Each frame is a start bit (0), then data sent LSB first, then an optional parity bit, then 1 or 2 stop bits (1). `word_len` 0/1/2/3 selects 5/6/7/8 data bits. Parity is present when `parity_en`=1; `parity_even`=1 selects even parity and 0 selects odd. `two_stop`=1 selects two stop bits. Framing is captured when a byte is loaded.
- R5: Each serial bit lasts 16*`divisor` clock cycles, and a divisor of 0 behaves as 1.
- R6: In legacy mode with `thre_ie`=1, `thre_irq` is high one cycle after the holding register becomes empty. It drops one cycle after a written character occupies it.
- R7: In FIFO mode with `thre_ie`=1, `thre_irq` is high whenever `fifo_level` <= `tx_trig`*4. Thus `tx_trig` 0/1/2/3 gives thresholds of 0/4/8/12, and the flag updates one cycle after the level changes.
- R8: With `thre_ie`=0, `thre_irq` stays low.
- R9: `thr_empty` is high when the holding FIFO holds nothing. `tx_empty` is high only when both the FIFO and the serializer are empty, and TX is then high.
- R10: A change of `fifo_mode` empties the holding FIFO on that clock (level 0 on the next cycle). A character already being serialized still completes.
- R11: After synchronous reset, TX is high, the FIFO is empty, `thr_empty`=1, `tx_empty`=1, `fifo_full`=0 and `thre_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe into the holding FIFO |
| wr_data | input | 8 | Byte to transmit |
| divisor | input | 16 | Clock divisor for the 16x tick (0 acts as 1) |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en | input | 1 | Append a parity bit |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| fifo_mode | input | 1 | 1 = 16-deep FIFO mode, 0 = single-byte legacy mode |
| thre_ie | input | 1 | Holding-empty interrupt enable |
| tx_trig | input | 2 | FIFO-mode interrupt threshold select (level <= 4*tx_trig) |
| tx | output | 1 | Serial output, idle high |
| thre_irq | output | 1 | Holding-empty interrupt |
| thr_empty | output | 1 | Holding FIFO empty |
| tx_empty | output | 1 | FIFO and serializer both empty |
| fifo_full | output | 1 | Holding register full for the current mode |
| fifo_level | output | 5 | Number of bytes held |

## Verification
The assertions expect inputs driven synchronously and free of X after reset. They also expect the divisor to hold steady while a character is on the line, because the level and interrupt properties assume one character moves per frame time. The bench changes framing and divisor only between characters, or during the final stop bit of a frame whose samples it has already taken. It toggles `fifo_mode` only on purpose, to exercise the flush. Frame capture starts its sampling from the observed falling edge of the start bit, so it depends on no internal latency except where the spacing between two starts is itself the requirement.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_MAX = 12;

  typedef enum logic {SH_IDLE, SH_SEND} sh_state_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } frame_cfg_t;

  // total bits on the line: start + (5+wlen) + parity + 1 or 2 stop
  function automatic logic [3:0] frame_len(frame_cfg_t c);
    return 4'd7 + {2'b00, c.wlen} + {3'b000, c.par_en} + {3'b000, c.two_stop};
  endfunction

  // bit 0 goes out first; unused upper bits stay 1 (stop / idle level)
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, frame_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic                 par;
    int                   n;
    n   = 5 + int'(c.wlen);
    f   = '1;
    f[0] = 1'b0;
    par = ~c.par_even;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        f[i+1] = d[i];
        par    = par ^ d[i];
      end
    end
    if (c.par_en) f[n+1] = par;
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         cap_one,
  input  logic                         wr,
  input  logic [W-1:0]                 din,
  input  logic                         rd,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             accept, take;

  assign empty  = (level == '0);
  assign full   = cap_one ? (level != '0) : (level == LVL_W'(DEPTH));
  assign accept = wr && !full && !flush;
  assign take   = rd && !empty && !flush;
  assign dout   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= din;
  end

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (accept) wp <= bump(wp);
      if (take)   rp <= bump(rp);
      case ({accept, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= reload;
    else if (cnt == '0)   cnt <= reload;
    else                  cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  input  frame_cfg_t cfg,
  output logic       pop,
  output logic       busy,
  output logic       tx
);

  localparam int SUB_W = $clog2(OVERSAMPLE);

  sh_state_t            state;
  logic [FRAME_MAX-1:0] shreg;
  logic [FRAME_MAX-1:0] load_frame;
  logic [3:0]           bits_left;
  logic [SUB_W-1:0]     sub;

  assign load_frame = build_frame(fifo_dout, cfg);
  assign pop        = (state == SH_IDLE) && !fifo_empty;
  assign busy       = (state == SH_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SH_IDLE;
      tx        <= 1'b1;
      shreg     <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else begin
      case (state)
        SH_IDLE: begin
          tx <= 1'b1;
          if (!fifo_empty) begin
            tx        <= load_frame[0];
            shreg     <= {1'b1, load_frame[FRAME_MAX-1:1]};
            bits_left <= frame_len(cfg) - 4'd1;
            sub       <= '0;
            state     <= SH_SEND;
          end
        end
        SH_SEND: begin
          if (tick) begin
            sub <= sub + 1'b1;
            if (sub == SUB_W'(OVERSAMPLE-1)) begin
              if (bits_left == 4'd0) begin
                state <= SH_IDLE;
                tx    <= 1'b1;
              end else begin
                tx        <= shreg[0];
                shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
                bits_left <= bits_left - 4'd1;
              end
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16,
  parameter int LVL_W      = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             parity_even,
  input  logic             two_stop,
  input  logic             fifo_mode,
  input  logic             thre_ie,
  input  logic [1:0]       tx_trig,
  output logic             tx,
  output logic             thre_irq,
  output logic             thr_empty,
  output logic             tx_empty,
  output logic             fifo_full,
  output logic [LVL_W-1:0] fifo_level
);

  localparam int STEP = DEPTH / 4;

  frame_cfg_t       cfg;
  logic             mode_q, flush;
  logic             pop, busy, tick, f_empty;
  logic [7:0]       f_dout;
  logic [LVL_W-1:0] thresh;
  logic             irq_next;

  assign cfg   = '{wlen: word_len, par_en: parity_en, par_even: parity_even, two_stop: two_stop};
  assign flush = (fifo_mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_mode;
  end

  uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .cap_one(!fifo_mode),
    .wr(wr_en), .din(wr_data), .rd(pop), .dout(f_dout),
    .level(fifo_level), .empty(f_empty), .full(fifo_full)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .divisor(divisor), .tick(tick)
  );

  uart_tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .fifo_empty(f_empty),
    .fifo_dout(f_dout), .cfg(cfg), .pop(pop), .busy(busy), .tx(tx)
  );

  assign thresh    = LVL_W'(int'(tx_trig) * STEP);
  assign thr_empty = f_empty;
  assign tx_empty  = f_empty && !busy;

  always_comb begin
    if (fifo_mode) irq_next = thre_ie && (fifo_level <= thresh);
    else           irq_next = thre_ie && f_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) thre_irq <= 1'b0;
    else     thre_irq <= irq_next;
  end

endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             fifo_mode,
  input logic             thre_ie,
  input logic             tx,
  input logic             thre_irq,
  input logic             thr_empty,
  input logic             tx_empty,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level
);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && wr_en && $stable(fifo_mode)) |=> (fifo_level <= $past(fifo_level)));

  // R2
  legacy_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && !$past(fifo_mode)) |-> (fifo_level <= 1));

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !thre_ie |=> !thre_irq);

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (tx && thr_empty));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx) |-> !tx_empty);

  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode != $past(fifo_mode)) |=> (fifo_level == '0));

endmodule

bind uart_tx_path uart_tx_path_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fifo_mode(fifo_mode),
  .thre_ie(thre_ie), .tx(tx), .thre_irq(thre_irq), .thr_empty(thr_empty),
  .tx_empty(tx_empty), .fifo_full(fifo_full), .fifo_level(fifo_level)
);

// File: tb/uart_tx_path_bench.sv
module uart_tx_path_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  word_len = 2'd3;
  logic        parity_en = 1'b0;
  logic        parity_even = 1'b0;
  logic        two_stop = 1'b0;
  logic        fifo_mode = 1'b0;
  logic        thre_ie = 1'b0;
  logic [1:0]  tx_trig = 2'd0;
  logic        tx, thre_irq, thr_empty, tx_empty, fifo_full;
  logic [4:0]  fifo_level;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_path u_uart_tx_path (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .divisor(divisor),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .two_stop(two_stop), .fifo_mode(fifo_mode), .thre_ie(thre_ie), .tx_trig(tx_trig),
    .tx(tx), .thre_irq(thre_irq), .thr_empty(thr_empty), .tx_empty(tx_empty),
    .fifo_full(fifo_full), .fifo_level(fifo_level)
  );

  // {data, word_len, parity_en, parity_even, two_stop, divisor}
  localparam logic [28:0] VECS [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 16'd1},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 16'd2},
    {8'h5A, 2'd3, 1'b1, 1'b0, 1'b1, 16'd1},
    {8'h1F, 2'd0, 1'b0, 1'b0, 1'b0, 16'd1},
    {8'hF3, 2'd1, 1'b1, 1'b1, 1'b1, 16'd3},
    {8'h6D, 2'd2, 1'b1, 1'b0, 1'b0, 16'd0},
    {8'h81, 2'd3, 1'b0, 1'b0, 1'b1, 16'd1},
    {8'hFF, 2'd0, 1'b1, 1'b0, 1'b1, 16'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = base + 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int n, input logic ev);
    logic p;
    p = ~ev;
    for (int i = 0; i < 8; i++) if (i < n) p = p ^ d[i];
    return p;
  endfunction

  // samples one frame at bit centres, timed from the observed start edge
  task automatic capture(input int div, input int nd, input bit pe, input bit ts,
                         output logic [7:0] d, output logic p, output bit stop_ok,
                         output bit start_ok, output int t0);
    int per;
    per = 16 * ((div == 0) ? 1 : div);
    d = 8'h00;
    p = 1'b0;
    while (tx !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (per / 2) @(negedge clk);
    start_ok = (tx == 1'b0);
    for (int i = 0; i < nd; i++) begin
      repeat (per) @(negedge clk);
      d[i] = tx;
    end
    if (pe) begin
      repeat (per) @(negedge clk);
      p = tx;
    end
    repeat (per) @(negedge clk);
    stop_ok = (tx == 1'b1);
    if (ts) begin
      repeat (per) @(negedge clk);
      stop_ok = stop_ok && (tx == 1'b1);
    end
  endtask

  initial begin
    logic [7:0] d1, d2, got [17];
    logic p1, p2;
    bit s1, s2, st1, st2, line_ok;
    int t1, t2, tdummy;

    idle(3);
    rst = 1'b0;
    idle(3);
    // R11 reset state, R8 with interrupt disabled
    check("R11 tx idle", tx, 1);
    check("R11 thr_empty", thr_empty, 1);
    check("R11 tx_empty", tx_empty, 1);
    check("R11 fifo_full", fifo_full, 0);
    check("R11 level", fifo_level, 0);
    check("R8 irq disabled", thre_irq, 0);

    // R4 R5 R3: table of framings and divisors, two characters each
    fifo_mode = 1'b1;
    idle(2);
    for (int v = 0; v < 8; v++) begin
      logic [7:0] dat, mask;
      int nd, div, nbits;
      bit pe, ev, ts;
      dat = VECS[v][28:21];
      nd  = 5 + int'(VECS[v][20:19]);
      pe  = VECS[v][18];
      ev  = VECS[v][17];
      ts  = VECS[v][16];
      div = int'(VECS[v][15:0]);
      mask = 8'((16'h1 << nd) - 1);
      nbits = 2 + nd + int'(pe) + int'(ts);
      @(negedge clk);
      word_len = VECS[v][20:19];
      parity_en = pe;
      parity_even = ev;
      two_stop = ts;
      divisor = VECS[v][15:0];
      fork
        begin
          capture(div, nd, pe, ts, d1, p1, s1, st1, t1);
          capture(div, nd, pe, ts, d2, p2, s2, st2, t2);
        end
        begin
          put(dat);
          put(dat ^ 8'hFF);
        end
      join
      check($sformatf("R4 v%0d start bit", v), int'(st1 && st2), 1);
      check($sformatf("R4 v%0d data1", v), d1, dat & mask);
      check($sformatf("R4 v%0d data2", v), d2, (dat ^ 8'hFF) & mask);
      if (pe) begin
        check($sformatf("R4 v%0d parity1", v), p1, exp_par(dat, nd, ev));
        check($sformatf("R4 v%0d parity2", v), p2, exp_par(dat ^ 8'hFF, nd, ev));
      end
      check($sformatf("R4 v%0d stop bits", v), int'(s1 && s2), 1);
      // R5 R3 spacing of two queued characters
      n_chk++;
      if ((t2 - t1) < nbits * 16 * ((div == 0) ? 1 : div) ||
          (t2 - t1) > nbits * 16 * ((div == 0) ? 1 : div) + 2) begin
        n_fail++;
        $display("FAIL R5 v%0d spacing actual=%0d expected=%0d", v, t2 - t1,
                 nbits * 16 * ((div == 0) ? 1 : div) + 1);
      end
    end
    while (!tx_empty) @(negedge clk);

    // R1 fill to depth in FIFO mode, extra write dropped, order kept
    @(negedge clk);
    word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0; divisor = 16'd1;
    fork
      begin
        for (int k = 0; k < 17; k++)
          capture(1, 8, 1'b0, 1'b0, got[k], p1, s1, st1, tdummy);
      end
      begin
        burst(18, 8'h40);
        check("R1 level at depth", fifo_level, 16);
        check("R1 full flag", fifo_full, 1);
        put(8'hEE);
        check("R1 write when full ignored", fifo_level, 16);
      end
    join
    for (int k = 0; k < 17; k++)
      check($sformatf("R1 order byte %0d", k), got[k], 8'h40 + 8'(k));
    while (!tx_empty) @(negedge clk);
    line_ok = 1;
    repeat (400) begin
      @(negedge clk);
      if (tx !== 1'b1) line_ok = 0;
    end
    check("R1 dropped bytes never sent", int'(line_ok), 1);

    // R6 R2 R9 legacy single-byte holding register
    @(negedge clk);
    fifo_mode = 1'b0;
    thre_ie = 1'b1;
    divisor = 16'd4;
    idle(4);
    check("R6 irq when empty", thre_irq, 1);
    fork
      begin
        capture(4, 8, 1'b0, 1'b0, d1, p1, s1, st1, tdummy);
        capture(4, 8, 1'b0, 1'b0, d2, p2, s2, st2, tdummy);
      end
      begin
        put(8'hC3);
        idle(4);
        put(8'h2B);
        idle(1);
        check("R6 irq cleared by write", thre_irq, 0);
        check("R2 full with one byte", fifo_full, 1);
        put(8'h77);
        check("R2 second byte ignored", fifo_level, 1);
        while (!thr_empty) @(negedge clk);
        check("R9 tx_empty low while shifting", tx_empty, 0);
        idle(2);
        check("R6 irq again after move", thre_irq, 1);
      end
    join
    check("R2 first byte", d1, 8'hC3);
    check("R2 second byte", d2, 8'h2B);
    while (!tx_empty) @(negedge clk);
    check("R9 tx_empty idle line", tx, 1);
    line_ok = 1;
    repeat (1200) begin
      @(negedge clk);
      if (tx !== 1'b1) line_ok = 0;
    end
    check("R2 dropped byte never sent", int'(line_ok), 1);
    @(negedge clk);
    thre_ie = 1'b0;
    idle(3);
    check("R8 irq masked", thre_irq, 0);

    // R7 threshold, then R10 flush on mode change
    @(negedge clk);
    fifo_mode = 1'b1;
    thre_ie = 1'b1;
    tx_trig = 2'd2;
    divisor = 16'd1;
    idle(4);
    check("R7 irq at level 0", thre_irq, 1);
    burst(10, 8'h10);
    idle(1);
    check("R7 level after burst", fifo_level, 9);
    check("R7 irq above threshold", thre_irq, 0);
    while (fifo_level != 5'd8) @(negedge clk);
    idle(2);
    check("R7 irq at threshold", thre_irq, 1);
    @(negedge clk);
    fifo_mode = 1'b0;
    @(negedge clk);
    check("R10 flushed level", fifo_level, 0);
    check("R10 thr_empty", thr_empty, 1);
    check("R10 frame in flight", tx_empty, 0);
    while (!tx_empty) @(negedge clk);
    check("R10 line idle after frame", tx, 1);

    // R11 reset while busy
    @(negedge clk);
    fifo_mode = 1'b1;
    idle(2);
    burst(5, 8'h90);
    idle(20);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    thre_ie = 1'b0;
    idle(1);
    check("R11 mid reset tx", tx, 1);
    check("R11 mid reset level", fifo_level, 0);
    check("R11 mid reset tx_empty", tx_empty, 1);

    finish_run();
  end

endmodule